// File: doc/BRIEF.md
# Alarm-Driven Power Rail Controller

This block owns the enable line of an external power-management device. A calendar unit outside the block raises a one-cycle alarm-match pulse; when software has armed rail control, that pulse drops the enable line and asks the power device to switch the rail off. The rail stays off until one of four external wakeup inputs reaches its programmed active level, or until reset.

Each wakeup input has its own enable bit and its own polarity bit in a 32-bit control register. Each input passes through a two-flop synchronizer and then through a polarity XOR before the enable mask is applied. The same alarm pulse also sets a sticky status flag. Software clears the flag by writing 1 to it. An interrupt enable in a separate register gates the flag onto a registered interrupt output. The interrupt enable register only takes a full-word write.

Software reaches the registers through a simple one-cycle write strobe with byte enables and a read strobe whose data comes back one cycle later.

Top module: `pwr_wake_ctl`

## Requirements
- R1: After reset, `pwr_en` is 1 and `alarm_irq` is 0. The control, status and interrupt-enable registers all read 0.
- R2: The control register is at offset 0x98. Bits 3:0 enable wakeup pins 3..0. Bits 7:4 are their polarities. Bit 16 arms rail control. All other bits read 0. Each byte lane is written only when its byte enable is set.
- R3: An alarm-match pulse sets the alarm flag, bit 7 of the status register at offset 0x44. It does so whatever the other settings are.
- R4: A status write with byte 0 enabled and bit 7 set clears the flag. Writing 0 to bit 7 leaves the flag unchanged. A match in the same cycle as a clear leaves the flag set.
- R5: The alarm interrupt enable is bit 4 of the register at offset 0x48. It changes only on a write with all four byte enables set. A partial write is ignored.
- R6: `alarm_irq` is high one cycle after the flag and the interrupt enable are both set. It falls one cycle after either is cleared.
- R7: With bit 16 set, a match pulse sampled at clock edge k drives `pwr_en` low after edge k.
- R8: With bit 16 clear, a match pulse leaves `pwr_en` at 1.
- R9: While the rail is off, an enabled pin is active when its synchronized level XOR its polarity bit is 1, so polarity 1 means active-low. A level applied before edge k raises `pwr_en` after edge k+2.
- R10: While the rail is off, a disabled pin, or an enabled pin at its inactive level, leaves `pwr_en` at 0.
- R11: Clearing the alarm flag does not turn the rail back on.
- R12: Read data appears on `reg_rdata` after the clock edge that samples `reg_rd`. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Write byte enables |
| reg_rdata | output | 32 | Registered read data |
| alarm_match | input | 1 | One-cycle pulse from the calendar's second alarm comparator |
| wake_in | input | 4 | Asynchronous wakeup pins |
| pwr_en | output | 1 | Enable line to the external power device |
| alarm_irq | output | 1 | Registered alarm interrupt |

## Verification
The assertions assume that `alarm_match` is a synchronous pulse and that register strobes last one cycle. The bench drives every input on the falling clock edge and never holds a strobe for more than a cycle. The assertions also assume that the rail can only rise through the synchronized wakeup path. For that reason the stimulus parks each wakeup pin at its inactive level for several cycles before it fires an alarm. A stale synchronizer value therefore cannot count as a wakeup. The sweep covers every pin under both polarities, with its enable on and off and at both levels.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;
  localparam int CTRL_ARM_BIT = 16;
  localparam int STAT_FLAG_BIT = 7;
  localparam int IRQ_EN_BIT = 4;

  typedef enum logic [0:0] {
    RAIL_ON  = 1'b0,
    RAIL_OFF = 1'b1
  } rail_state_t;
endpackage

// File: rtl/pwr_wake_sync.sv
module pwr_wake_sync #(
  parameter int NUM_WAKE = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_WAKE-1:0] wake_in,
  input  logic [NUM_WAKE-1:0] pin_en,
  input  logic [NUM_WAKE-1:0] pin_pol,
  output logic                wake_hit
);
  logic [NUM_WAKE-1:0] active;

  for (genvar i = 0; i < NUM_WAKE; i++) begin : g_pin
    logic [SYNC_STAGES-1:0] stage_q;
    always_ff @(posedge clk) begin
      if (rst) stage_q <= '0;
      else     stage_q <= {stage_q[SYNC_STAGES-2:0], wake_in[i]};
    end
    // level XOR polarity, then mask
    assign active[i] = (stage_q[SYNC_STAGES-1] ^ pin_pol[i]) & pin_en[i];
  end

  assign wake_hit = |active;
endmodule

// File: rtl/pwr_wake_regs.sv
module pwr_wake_regs
  import pwr_wake_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int NUM_WAKE = 4,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h98,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h44,
  parameter logic [ADDR_W-1:0] IRQ_OFS  = 8'h48
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_we,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  input  logic [DATA_W/8-1:0] reg_be,
  input  logic                alarm_match,
  output logic                arm,
  output logic [NUM_WAKE-1:0] pin_en,
  output logic [NUM_WAKE-1:0] pin_pol,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                alarm_irq
);
  localparam int BE_W = DATA_W / 8;
  localparam logic [DATA_W-1:0] PIN_MASK = DATA_W'((64'd1 << (2 * NUM_WAKE)) - 64'd1);
  localparam logic [DATA_W-1:0] ARM_MASK = DATA_W'(64'd1 << CTRL_ARM_BIT);
  localparam logic [DATA_W-1:0] CTRL_MASK = PIN_MASK | ARM_MASK;

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] wmask;
  logic              flag_q;
  logic              irq_en_q;
  logic              ctrl_wr, stat_wr, irq_wr, flag_clr;

  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    assign wmask[b*8 +: 8] = {8{reg_be[b]}};
  end

  assign ctrl_wr  = reg_we && (reg_addr == CTRL_OFS);
  assign stat_wr  = reg_we && (reg_addr == STAT_OFS);
  assign irq_wr   = reg_we && (reg_addr == IRQ_OFS);
  assign flag_clr = stat_wr && reg_be[STAT_FLAG_BIT/8] && reg_wdata[STAT_FLAG_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      flag_q    <= 1'b0;
      irq_en_q  <= 1'b0;
      alarm_irq <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (ctrl_wr)
        ctrl_q <= ((ctrl_q & ~wmask) | (reg_wdata & wmask)) & CTRL_MASK;
      if (alarm_match)   flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
      if (irq_wr && (&reg_be))
        irq_en_q <= reg_wdata[IRQ_EN_BIT];
      alarm_irq <= flag_q & irq_en_q;
      if (reg_rd) begin
        if (reg_addr == CTRL_OFS)      reg_rdata <= ctrl_q;
        else if (reg_addr == STAT_OFS) reg_rdata <= DATA_W'(flag_q) << STAT_FLAG_BIT;
        else if (reg_addr == IRQ_OFS)  reg_rdata <= DATA_W'(irq_en_q) << IRQ_EN_BIT;
        else                           reg_rdata <= '0;
      end
    end
  end

  assign arm     = ctrl_q[CTRL_ARM_BIT];
  assign pin_en  = ctrl_q[NUM_WAKE-1:0];
  assign pin_pol = ctrl_q[2*NUM_WAKE-1:NUM_WAKE];

  // R3
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    alarm_match |=> flag_q);

  // R4
  flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !alarm_match) |=> !flag_q);

  // R5
  irq_partial_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_wr && !(&reg_be)) |=> $stable(irq_en_q));
endmodule

// File: rtl/pwr_wake_fsm.sv
module pwr_wake_fsm
  import pwr_wake_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic alarm_match,
  input  logic arm,
  input  logic wake_hit,
  output logic pwr_en
);
  rail_state_t state_q;

  always_ff @(posedge clk) begin
    if (rst) state_q <= RAIL_ON;
    else begin
      case (state_q)
        RAIL_ON:  if (alarm_match && arm) state_q <= RAIL_OFF;
        RAIL_OFF: if (wake_hit)           state_q <= RAIL_ON;
        default:                          state_q <= RAIL_ON;
      endcase
    end
  end

  assign pwr_en = (state_q == RAIL_ON);

  // R7
  rail_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_en) |-> $past(alarm_match && arm));

  // R9
  rail_wake_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_en) |-> $past(wake_hit));

  // R8
  rail_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_en && !arm) |=> pwr_en);
endmodule

// File: rtl/pwr_wake_ctl.sv
module pwr_wake_ctl #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int NUM_WAKE = 4,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h98,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h44,
  parameter logic [ADDR_W-1:0] IRQ_OFS  = 8'h48
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_we,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  input  logic [DATA_W/8-1:0] reg_be,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic                alarm_match,
  input  logic [NUM_WAKE-1:0] wake_in,
  output logic                pwr_en,
  output logic                alarm_irq
);
  logic                arm;
  logic [NUM_WAKE-1:0] pin_en;
  logic [NUM_WAKE-1:0] pin_pol;
  logic                wake_hit;

  pwr_wake_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_WAKE(NUM_WAKE),
    .CTRL_OFS(CTRL_OFS), .STAT_OFS(STAT_OFS), .IRQ_OFS(IRQ_OFS)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_be(reg_be),
    .alarm_match(alarm_match), .arm(arm), .pin_en(pin_en),
    .pin_pol(pin_pol), .reg_rdata(reg_rdata), .alarm_irq(alarm_irq)
  );

  pwr_wake_sync #(.NUM_WAKE(NUM_WAKE), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .wake_in(wake_in), .pin_en(pin_en),
    .pin_pol(pin_pol), .wake_hit(wake_hit)
  );

  pwr_wake_fsm u_fsm (
    .clk(clk), .rst(rst), .alarm_match(alarm_match), .arm(arm),
    .wake_hit(wake_hit), .pwr_en(pwr_en)
  );
endmodule

// File: tb/pwr_wake_ctl_bench.sv
module pwr_wake_ctl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_rdata;
  logic        alarm_match = 1'b0;
  logic [3:0]  wake_in = '0;
  logic        pwr_en;
  logic        alarm_irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [7:0] A_CTRL = 8'h98;
  localparam logic [7:0] A_STAT = 8'h44;
  localparam logic [7:0] A_IRQ  = 8'h48;

  always #4 clk = ~clk;

  pwr_wake_ctl u_pwr_wake_ctl (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_be(reg_be),
    .reg_rdata(reg_rdata), .alarm_match(alarm_match), .wake_in(wake_in),
    .pwr_en(pwr_en), .alarm_irq(alarm_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wake_in = '0; alarm_match = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_we = 1'b0; reg_be = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse_match();
    alarm_match = 1'b1;
    @(negedge clk);
    alarm_match = 1'b0;
  endtask

  initial begin
    logic [31:0] d;
    do_reset();
    // R1 reset state
    check("R1 pwr_en", {31'b0, pwr_en}, 32'h1);
    check("R1 irq", {31'b0, alarm_irq}, 32'h0);
    rd(A_CTRL, d); check("R1 ctrl", d, 32'h0);
    rd(A_STAT, d); check("R1 stat", d, 32'h0);
    rd(A_IRQ, d);  check("R1 irqen", d, 32'h0);

    // R2 writable bits and byte lanes
    wr(A_CTRL, 32'hFFFF_FFFF, 4'hF);
    rd(A_CTRL, d); check("R2 all ones", d, 32'h0001_00FF);
    wr(A_CTRL, 32'h0, 4'b0001);
    rd(A_CTRL, d); check("R2 lane0 only", d, 32'h0001_0000);
    wr(A_CTRL, 32'h0, 4'b1011);
    rd(A_CTRL, d); check("R2 lane2 kept", d, 32'h0001_0000);
    wr(A_CTRL, 32'h0, 4'hF);
    // R12 unmapped read
    rd(8'h10, d); check("R12 unmapped", d, 32'h0);

    // R5 partial write ignored, full write taken
    wr(A_IRQ, 32'h10, 4'b0111);
    rd(A_IRQ, d); check("R5 partial", d, 32'h0);
    wr(A_IRQ, 32'h10, 4'hF);
    rd(A_IRQ, d); check("R5 full", d, 32'h10);

    // R8 / R3 / R6: match with rail control unarmed
    pulse_match();
    check("R8 stays on", {31'b0, pwr_en}, 32'h1);
    @(negedge clk);
    check("R6 irq high", {31'b0, alarm_irq}, 32'h1);
    rd(A_STAT, d); check("R3 flag", d, 32'h80);

    // R4 writing 0 keeps flag, writing 1 clears
    wr(A_STAT, 32'h0, 4'hF);
    rd(A_STAT, d); check("R4 write zero", d, 32'h80);
    wr(A_STAT, 32'h80, 4'hF);
    rd(A_STAT, d); check("R4 cleared", d, 32'h0);
    check("R6 irq low", {31'b0, alarm_irq}, 32'h0);

    // R4 match wins over same-cycle clear
    pulse_match();
    reg_we = 1'b1; reg_addr = A_STAT; reg_wdata = 32'h80; reg_be = 4'hF;
    alarm_match = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; alarm_match = 1'b0;
    rd(A_STAT, d); check("R4 match wins", d, 32'h80);
    // R6 irq gated by enable
    wr(A_IRQ, 32'h0, 4'hF);
    @(negedge clk);
    check("R6 irq disabled", {31'b0, alarm_irq}, 32'h0);
    wr(A_STAT, 32'h80, 4'hF);

    // R7 / R11 armed drop, clear flag leaves rail off
    wr(A_CTRL, 32'h0001_0000, 4'hF);
    pulse_match();
    check("R7 off", {31'b0, pwr_en}, 32'h0);
    wr(A_STAT, 32'h80, 4'hF);
    repeat (3) @(negedge clk);
    check("R11 still off", {31'b0, pwr_en}, 32'h0);

    // R9 / R10 sweep: every pin, polarity, enable and level
    for (int pin = 0; pin < 4; pin++) begin
      for (int pol = 0; pol < 2; pol++) begin
        for (int en = 0; en < 2; en++) begin
          for (int lvl = 0; lvl < 2; lvl++) begin
            logic [31:0] cfg;
            logic exp_on;
            do_reset();
            wake_in = '0;
            wake_in[pin] = pol[0];
            cfg = 32'h0001_0000 | (32'(en) << pin) | (32'(pol) << (4 + pin));
            wr(A_CTRL, cfg, 4'hF);
            repeat (4) @(negedge clk);
            pulse_match();
            check("R7 sweep off", {31'b0, pwr_en}, 32'h0);
            wake_in[pin] = lvl[0];
            repeat (2) @(negedge clk);
            check("R9 sync delay", {31'b0, pwr_en}, 32'h0);
            @(negedge clk);
            exp_on = en[0] && (lvl[0] != pol[0]);
            if (exp_on) check("R9 wake", {31'b0, pwr_en}, 32'h1);
            else        check("R10 no wake", {31'b0, pwr_en}, 32'h0);
          end
        end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule